// File: doc/BRIEF.md
# Home-Node Write Coherence Sequencer

This block is the home-memory controller for one shared datum in a distributed-memory multiprocessor. It holds the central copy of the datum and a presence vector with one bit per node that records which nodes hold a cached copy. Requests arrive one at a time, each carrying a node number, a read/write flag and write data. A read returns the central copy at once and records the reader as a sharer.

A write locks the datum. While it is locked, every new request is held off with `req_ready` low, so requests are served in the order they arrive. In invalidate mode the block sends one invalidation to each sharer other than the writer, lowest node number first, one per cycle. It clears each sharer's presence bit as that sharer's acknowledgment returns. Once the vector holds no one but the writer, it commits the new value, makes the writer the only recorded sharer, signals completion to the writer and unlocks.

In update mode, selected per write by `update_mode`, the block first sends a lock message to every other sharer to make its copy unreadable, and waits for all of those acknowledgments. It then commits the central copy. Next it pushes the new value to the sharers one at a time, waiting for each sharer's acknowledgment (which releases that copy's read lock) before moving on to the next. Only then does it complete the write. A writer that is the only remote holder of the datum needs no network traffic, so it completes at once.

Top module: `coh_home_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `msg_valid` and `done_valid` are 0, the presence vector is empty and the central copy is 0.
- R2: A read accepted in one cycle gives `done_valid`=1, `done_write`=0, `done_node` equal to the reader and `done_data` equal to the central copy in the next cycle, and records the reader as a sharer.
- R3: An invalidate-mode write sends one message with `msg_kind`=0 (invalidate) to each recorded sharer other than the writer, one per cycle in ascending node order, starting the cycle after acceptance. No message goes to the writer.
- R4: The writer's completion (`done_valid`=1, `done_write`=1, `done_data`= the written value) is withheld until every message it sent has been acknowledged. It appears in the cycle after the last awaited acknowledgment is sampled.
- R5: `req_ready` is 0 from the cycle after a write is accepted through its completion cycle. It returns to 1 in the following cycle.
- R6: A write whose writer is the only sharer, or that finds no sharers, sends no message and completes in the cycle after acceptance.
- R7: After an invalidate-mode write completes, the writer is the only recorded sharer.
- R8: An update-mode write sends `msg_kind`=1 (lock) to each other sharer in ascending order. After all of those are acknowledged, it sends `msg_kind`=2 (update, `msg_data` = new value) to one sharer at a time, and sends each one only after the previous sharer has acknowledged. It completes after the last acknowledgment. All sharers stay recorded, plus the writer.
- R9: An acknowledgment from a node that is not awaited, including the writer, changes nothing.
- R10: A read after a write, in either mode, returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_node | input | NODE_W | Requesting node |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | DATA_W | Write data |
| update_mode | input | 1 | 1 = update protocol for this write, 0 = invalidate |
| msg_valid | output | 1 | Coherence message valid |
| msg_kind | output | 2 | 0 invalidate, 1 lock, 2 update |
| msg_dest | output | NODE_W | Destination node |
| msg_data | output | DATA_W | New value carried by update messages |
| ack_valid | input | 1 | Sharer acknowledgment present |
| ack_node | input | NODE_W | Acknowledging node |
| done_valid | output | 1 | Completion to the requester |
| done_node | output | NODE_W | Node being completed |
| done_write | output | 1 | Completion is for a write |
| done_data | output | DATA_W | Read data, or the value written |

## Verification
The bench targets the premature completion. A design that counted acknowledgments instead of matching them to awaited nodes would finish early on a stray acknowledgment from the writer. A design that ignored the acknowledgment vector would let the writer proceed while stale copies still exist. It checks the sole-sharer shortcut, where a design that always invalidated would send a message to the writer itself. It checks the one-at-a-time update push, where a design that broadcast the updates would put a second update on the wire before the first acknowledgment. It also checks that sharers are retained after update mode, while an invalidate write leaves only the writer recorded. A design that got this wrong would either miss an invalidation on the next write or send an extra one.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_COLLECT,
    ST_PUSH,
    ST_PUSH_WAIT,
    ST_FINISH
  } seq_state_t;

  typedef enum logic [1:0] {
    MSG_INV  = 2'd0,
    MSG_LOCK = 2'd1,
    MSG_UPD  = 2'd2
  } msg_kind_t;
endpackage

// File: rtl/coh_pick.sv
module coh_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  assign onehot = vec & (~vec + {{(N-1){1'b0}}, 1'b1});

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coh_sharer_dir.sv
module coh_sharer_dir #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         load_en,
  input  logic [N-1:0] load_vec,
  output logic [N-1:0] sharers
);
  logic [N-1:0] sharers_n;

  always_comb begin
    if (load_en) sharers_n = load_vec;
    else         sharers_n = (sharers & ~clr_vec) | (set_en ? set_vec : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sharers <= '0;
    else        sharers <= sharers_n;
  end
endmodule

// File: rtl/coh_seq_fsm.sv
module coh_seq_fsm
  import coh_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [IW-1:0] req_node,
  input  logic          req_update_mode,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_node,
  input  logic [N-1:0]  sharers,
  output logic          req_ready,
  output logic          msg_valid,
  output logic [1:0]    msg_kind,
  output logic [IW-1:0] msg_dest,
  output logic          done_valid,
  output logic          done_write,
  output logic [IW-1:0] done_node,
  output logic          commit,
  output logic          dir_set_en,
  output logic [N-1:0]  dir_set_vec,
  output logic [N-1:0]  dir_clr_vec,
  output logic          dir_load_en,
  output logic [N-1:0]  dir_load_vec,
  output logic          mode_upd
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  seq_state_t   state, state_n;
  logic [N-1:0] pend, pend_n, waitv, waitv_n, upd_left, upd_left_n, tgt, tgt_n;
  logic [IW-1:0] writer, writer_n;
  logic          wr_r, wr_n, mode_r, mode_n;
  logic [N-1:0]  pick_in, pick_oh, sent_oh, ack_oh, take, wr_oh, req_oh;
  logic [IW-1:0] pick_idx;

  assign pick_in = (state == ST_PUSH) ? upd_left : pend;

  coh_pick #(.N(N)) u_pick (.vec(pick_in), .onehot(pick_oh), .idx(pick_idx));

  assign wr_oh   = ONE << writer;
  assign req_oh  = ONE << req_node;
  assign ack_oh  = ack_valid ? (ONE << ack_node) : '0;
  assign take    = ack_oh & waitv;
  assign waitv_n = (waitv & ~take) | sent_oh;

  assign done_node   = writer;
  assign done_write  = wr_r;
  assign mode_upd    = mode_r;
  assign dir_clr_vec = mode_r ? '0 : take;
  assign dir_set_vec = wr_oh;

  always_comb begin
    state_n      = state;
    pend_n       = pend;
    upd_left_n   = upd_left;
    tgt_n        = tgt;
    writer_n     = writer;
    wr_n         = wr_r;
    mode_n       = mode_r;
    sent_oh      = '0;
    req_ready    = 1'b0;
    msg_valid    = 1'b0;
    msg_kind     = MSG_INV;
    msg_dest     = pick_idx;
    done_valid   = 1'b0;
    commit       = 1'b0;
    dir_set_en   = 1'b0;
    dir_load_en  = 1'b0;
    dir_load_vec = '0;
    unique case (state)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          writer_n = req_node;
          wr_n     = req_write;
          mode_n   = req_update_mode;
          tgt_n    = sharers & ~req_oh;
          pend_n   = sharers & ~req_oh;
          if (!req_write || ((sharers & ~req_oh) == '0)) state_n = ST_FINISH;
          else                                            state_n = ST_SEND;
        end
      end
      ST_SEND: begin
        msg_valid = 1'b1;
        msg_kind  = mode_r ? MSG_LOCK : MSG_INV;
        sent_oh   = pick_oh;
        pend_n    = pend & ~pick_oh;
        if ((pend & ~pick_oh) == '0) state_n = ST_COLLECT;
      end
      ST_COLLECT: begin
        if (waitv_n == '0) begin
          if (mode_r) begin
            upd_left_n = tgt;
            commit     = 1'b1;
            state_n    = ST_PUSH;
          end else begin
            state_n = ST_FINISH;
          end
        end
      end
      ST_PUSH: begin
        msg_valid  = 1'b1;
        msg_kind   = MSG_UPD;
        sent_oh    = pick_oh;
        upd_left_n = upd_left & ~pick_oh;
        state_n    = ST_PUSH_WAIT;
      end
      ST_PUSH_WAIT: begin
        if (waitv_n == '0) state_n = (upd_left == '0) ? ST_FINISH : ST_PUSH;
      end
      ST_FINISH: begin
        done_valid = 1'b1;
        if (wr_r) begin
          commit       = 1'b1;
          dir_load_en  = 1'b1;
          dir_load_vec = mode_r ? (sharers | wr_oh) : wr_oh;
        end else begin
          dir_set_en = 1'b1;
        end
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= '0;
      waitv    <= '0;
      upd_left <= '0;
      tgt      <= '0;
      writer   <= '0;
      wr_r     <= 1'b0;
      mode_r   <= 1'b0;
    end else begin
      state    <= state_n;
      pend     <= pend_n;
      waitv    <= waitv_n;
      upd_left <= upd_left_n;
      tgt      <= tgt_n;
      writer   <= writer_n;
      wr_r     <= wr_n;
      mode_r   <= mode_n;
    end
  end
endmodule

// File: rtl/coh_home_seq.sv
module coh_home_seq #(
  parameter int NODES  = 4,
  parameter int DATA_W = 16,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NODE_W-1:0] req_node,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_data,
  input  logic              update_mode,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_dest,
  output logic [DATA_W-1:0] msg_data,
  input  logic              ack_valid,
  input  logic [NODE_W-1:0] ack_node,
  output logic              done_valid,
  output logic [NODE_W-1:0] done_node,
  output logic              done_write,
  output logic [DATA_W-1:0] done_data
);
  logic [NODES-1:0]  sharer_vec, set_vec, clr_vec, load_vec;
  logic              set_en, load_en, commit, mode_upd, wdata_en;
  logic [DATA_W-1:0] central_q, central_n, wdata_q, wdata_n;

  coh_sharer_dir #(.N(NODES)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_vec(set_vec), .clr_vec(clr_vec),
    .load_en(load_en), .load_vec(load_vec), .sharers(sharer_vec)
  );

  coh_seq_fsm #(.N(NODES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_node(req_node),
    .req_update_mode(update_mode),
    .ack_valid(ack_valid), .ack_node(ack_node), .sharers(sharer_vec),
    .req_ready(req_ready), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .done_valid(done_valid), .done_write(done_write),
    .done_node(done_node), .commit(commit),
    .dir_set_en(set_en), .dir_set_vec(set_vec), .dir_clr_vec(clr_vec),
    .dir_load_en(load_en), .dir_load_vec(load_vec), .mode_upd(mode_upd)
  );

  assign wdata_en  = req_valid && req_ready && req_write;
  assign wdata_n   = wdata_en ? req_data : wdata_q;
  assign central_n = commit ? wdata_q : central_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q   <= '0;
      central_q <= '0;
    end else begin
      wdata_q   <= wdata_n;
      central_q <= central_n;
    end
  end

  assign msg_data  = wdata_q;
  assign done_data = done_write ? wdata_q : central_q;
endmodule

// File: rtl/coh_home_seq_chk.sv
module coh_home_seq_chk #(
  parameter int NODES  = 4,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              msg_valid,
  input logic [NODE_W-1:0] msg_dest,
  input logic              done_valid,
  input logic              done_write,
  input logic [NODE_W-1:0] done_node,
  input logic [NODES-1:0]  sharers,
  input logic              mode_upd
);
  logic [NODES-1:0] wr_oh;
  assign wr_oh = {{(NODES-1){1'b0}}, 1'b1} << done_node;

  AST_MSG_NOT_TO_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_dest != done_node)); // R3
  AST_MSG_TO_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> sharers[msg_dest]); // R3
  AST_LOCKED_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready); // R5
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> req_ready); // R5
  AST_DONE_NO_STALE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_write && !mode_upd) |-> ((sharers & ~wr_oh) == '0)); // R4
  AST_DONE_QUIET_NET: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !msg_valid); // R4
endmodule

bind coh_home_seq coh_home_seq_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .msg_valid(msg_valid),
  .msg_dest(msg_dest), .done_valid(done_valid), .done_write(done_write),
  .done_node(done_node), .sharers(sharer_vec), .mode_upd(mode_upd)
);

// File: tb/coh_home_seq_tb.sv
`timescale 1ns/1ps
module coh_home_seq_tb;
  localparam int NODES = 4;
  localparam int NW    = 2;
  localparam int DW    = 16;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, update_mode;
  logic [NW-1:0] req_node, msg_dest, ack_node, done_node;
  logic [DW-1:0] req_data, msg_data, done_data;
  logic msg_valid, ack_valid, done_valid, done_write;
  logic [1:0] msg_kind;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  coh_home_seq #(.NODES(NODES), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_write(req_write), .req_data(req_data),
    .update_mode(update_mode), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .msg_data(msg_data), .ack_valid(ack_valid),
    .ack_node(ack_node), .done_valid(done_valid), .done_node(done_node),
    .done_write(done_write), .done_data(done_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog: run hung actual=%0d expected<%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // drive one request for one edge; outputs observed afterwards
  task automatic issue(input int n, input bit w, input int d, input bit m);
    @(negedge clk);
    chk("R5 ready before issue", req_ready == 1'b1, req_ready, 1);
    req_valid = 1'b1; req_node = NW'(n); req_write = w;
    req_data = DW'(d); update_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack(input int n);
    ack_valid = 1'b1; ack_node = NW'(n);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic expect_msg(input string r, input int kind, input int dest);
    chk({r, " msg_valid"}, msg_valid == 1'b1, msg_valid, 1);
    chk({r, " msg_kind"}, msg_kind == 2'(kind), msg_kind, kind);
    chk({r, " msg_dest"}, msg_dest == NW'(dest), msg_dest, dest);
  endtask

  task automatic expect_done(input string r, input int n, input bit w, input int d);
    chk({r, " done_valid"}, done_valid == 1'b1, done_valid, 1);
    chk({r, " done_node"}, done_node == NW'(n), done_node, n);
    chk({r, " done_write"}, done_write == w, done_write, w);
    chk({r, " done_data"}, done_data == DW'(d), done_data, d);
  endtask

  task automatic do_read(input int n, input int expd);
    issue(n, 1'b0, 0, 1'b0);
    expect_done("R2 R10 read", n, 1'b0, expd);
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready == 1'b1, req_ready, 1);
    chk("R1 msg", msg_valid == 1'b0, msg_valid, 0);
    chk("R1 done", done_valid == 1'b0, done_valid, 0);
    // empty sharers: a write finds nobody to invalidate
    issue(3, 1'b1, 16'h0, 1'b0);
    chk("R1 empty vector no msg", msg_valid == 1'b0, msg_valid, 0);
    expect_done("R1 R6 write to empty", 3, 1'b1, 16'h0);
  endtask

  task automatic t_reads();
    do_read(0, 0);
    do_read(1, 0);
    do_read(2, 0);
    @(negedge clk);
    chk("R2 single cycle done", done_valid == 1'b0, done_valid, 0);
  endtask

  task automatic t_invalidate();
    // sharers {0,1,2,3}; node 2 writes
    issue(2, 1'b1, 16'hA5A5, 1'b0);
    expect_msg("R3 first", 0, 0);
    chk("R5 locked", req_ready == 1'b0, req_ready, 0);
    @(negedge clk); expect_msg("R3 second", 0, 1);
    @(negedge clk); expect_msg("R3 third", 0, 3);
    @(negedge clk);
    chk("R3 no more msgs", msg_valid == 1'b0, msg_valid, 0);
    ack(2);
    chk("R9 writer ack ignored", done_valid == 1'b0, done_valid, 0);
    ack(3);
    ack(3);
    chk("R9 duplicate ack ignored", done_valid == 1'b0, done_valid, 0);
    ack(1);
    chk("R4 waiting for node 0", done_valid == 1'b0, done_valid, 0);
    chk("R5 still locked", req_ready == 1'b0, req_ready, 0);
    ack(0);
    expect_done("R4 write done", 2, 1'b1, 16'hA5A5);
    @(negedge clk);
    chk("R5 unlocked", req_ready == 1'b1, req_ready, 1);
  endtask

  task automatic t_sole();
    // sharers {2}: node 2 rewrites
    issue(2, 1'b1, 16'h0F0F, 1'b0);
    chk("R6 no msg", msg_valid == 1'b0, msg_valid, 0);
    expect_done("R6 sole writer", 2, 1'b1, 16'h0F0F);
    // node 0 writes: only node 2 invalidated
    issue(0, 1'b1, 16'h5151, 1'b0);
    expect_msg("R7 only prior writer", 0, 2);
    @(negedge clk);
    chk("R7 exactly one msg", msg_valid == 1'b0, msg_valid, 0);
    ack(2);
    expect_done("R7 done", 0, 1'b1, 16'h5151);
    do_read(1, 16'h5151);
  endtask

  task automatic t_update();
    do_read(2, 16'h5151);
    do_read(3, 16'h5151);
    // sharers {0,1,2,3}; node 1 writes in update mode
    issue(1, 1'b1, 16'h1234, 1'b1);
    expect_msg("R8 lock a", 1, 0);
    @(negedge clk); expect_msg("R8 lock b", 1, 2);
    @(negedge clk); expect_msg("R8 lock c", 1, 3);
    @(negedge clk);
    chk("R8 quiet after locks", msg_valid == 1'b0, msg_valid, 0);
    ack(0);
    ack(2);
    chk("R8 no update before all lock acks", msg_valid == 1'b0, msg_valid, 0);
    ack(3);
    expect_msg("R8 update a", 2, 0);
    chk("R8 update data", msg_data == 16'h1234, msg_data, 16'h1234);
    @(negedge clk);
    chk("R8 one at a time", msg_valid == 1'b0, msg_valid, 0);
    ack(3);
    chk("R9 unawaited ack ignored", msg_valid == 1'b0 && done_valid == 1'b0,
        msg_valid, 0);
    ack(0);
    expect_msg("R8 update b", 2, 2);
    @(negedge clk);
    ack(2);
    expect_msg("R8 update c", 2, 3);
    @(negedge clk);
    chk("R4 no done before last ack", done_valid == 1'b0, done_valid, 0);
    ack(3);
    expect_done("R8 update done", 1, 1'b1, 16'h1234);
    do_read(3, 16'h1234);
    // sharers retained: node 0 write invalidates 1,2,3
    issue(0, 1'b1, 16'h7777, 1'b0);
    expect_msg("R8 retained 1", 0, 1);
    @(negedge clk); expect_msg("R8 retained 2", 0, 2);
    @(negedge clk); expect_msg("R8 retained 3", 0, 3);
    @(negedge clk);
    ack(1); ack(2); ack(3);
    expect_done("R4 final write", 0, 1'b1, 16'h7777);
    do_read(2, 16'h7777);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_node = '0; req_write = 1'b0;
    req_data = '0; update_mode = 1'b0; ack_valid = 1'b0; ack_node = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_invalidate();
    t_sole();
    t_update();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule